// File: doc/BRIEF.md
# Powered-Device Mode Sequencer

This block follows the operating mode of an Ethernet powered device from a stream of port-voltage codes, one code per clock. Each code is sorted into a voltage band, and a band change is taken only after it has persisted for a set number of samples. A state machine then moves through reset, signature, classification, mark, inrush and powered-on. From these states it drives the enables for the signature load, the classification load, the mark load and the hot-swap gate.

The machine counts classification events. One event before power-up identifies a single-event source. Two events with a mark phase between them identify a two-event source. Once power is good, the result is shown on one open-drain type line:
- released (high) for a single-event source,
- held low for a two-event source,
- a 50% square wave when the source has also been mutually identified as an extended high-power source.

Two inputs override the normal sequence:
- An auxiliary-supply input takes the device off the port.
- An over-temperature input forces the device into a safe state. It takes precedence over the auxiliary input.

Top module: `pd_mode_seq`

## Requirements
- R1: After reset, mode_o is 0 (rest). All three loads and gate_on_o are 0, pgood_o is 0 (line pulled low) and type_o is 1 (released). Mode codes: 0 rest, 1 signature, 2 classification, 3 mark, 4 inrush, 5 powered.
- R2: A new voltage band takes effect only after DEB_LEN consecutive samples in that band. With DEB_LEN=4, a code applied before posedge 1 changes mode_o after posedge DEB_LEN+1 and not earlier. A shorter excursion has no effect.
- R3: A code from 10 up to the classification entry level (with a 0.25 V LSB) puts the device in signature mode with sig_load_o=1. At most one of sig_load_o, cls_load_o, mark_load_o and gate_on_o is high at a time.
- R4: Classification is entered at codes 50..84. While in classification, the device stays there down to code 46, and a code below 46 moves it to mark (mark_load_o=1). From mark, it re-enters classification only at code 50 or above. Mark is entered only from classification.
- R5: A code below 10 returns the device to rest from any mode and clears the event count and the recorded source type.
- R6: With low_volt_i=0, the gate turns on above code 148 and off below code 120. With low_volt_i=1, it turns on above 116 and off below 86.
- R7: pgood_o stays 0 through classification and inrush. It goes to 1 only in powered mode, which is entered from inrush when gate_enh_i is high. When the port falls below the turn-off level, the device returns to signature mode with gate_on_o=0 and pgood_o=0.
- R8: type_o is 1 until power is good. In powered mode, type_o is 1 after one classification event and 0 after two.
- R9: In powered mode, ext_id_i marks the source as extended, and type_o then toggles with a half-period of IND_HALF_CYC clocks. Each time the wave is enabled, it starts with a low half.
- R10: With aux_i=1 and otemp_i=0, all loads are 0, gate_on_o=0, pgood_o=1, and the mode is forced to rest.
- R11: During the auxiliary override, type_o is held at 0 when ext_fitted_i=0. When ext_fitted_i=1, it carries the square wave, starting low.
- R12: With otemp_i=1, gate_on_o=0, pgood_o=0, all loads are 0, type_o=1 and the mode is forced to rest, whatever aux_i is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one voltage sample per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vport_code_i | input | VW | Port voltage code, 0.25 V per LSB |
| low_volt_i | input | 1 | 1 selects the lower gate thresholds |
| gate_enh_i | input | 1 | Gate has reached full enhancement |
| ext_id_i | input | 1 | Source mutually identified as extended |
| ext_fitted_i | input | 1 | Extended classification option present |
| aux_i | input | 1 | Auxiliary supply above its threshold |
| otemp_i | input | 1 | Over-temperature condition |
| sig_load_o | output | 1 | Signature load enable |
| cls_load_o | output | 1 | Classification load enable |
| mark_load_o | output | 1 | Mark load enable |
| gate_on_o | output | 1 | Hot-swap gate drive |
| pgood_o | output | 1 | Power-good line, 0 = pulled low, 1 = released |
| type_o | output | 1 | Source-type line, 0 = pulled low, 1 = released |
| mode_o | output | 3 | Current mode code |

## Verification
The bench targets the following corner cases:
- **Filter length.** An excursion one sample short of the filter length must not move the mode. A filter that is off by one either accepts it or responds a cycle late.
- **Classification hysteresis.** Codes 46..49 must keep the device in classification but must not bring it back from mark. A single threshold would bounce between the two modes or miss the second event and report a single-event source.
- **Threshold sets and power loss.** Both gate threshold sets are driven, including a code that lies in the on-band of only one set. The port is dropped from powered mode and the clearing of the event count is checked.
- **Overrides and the square wave.** The override precedence is exercised with both inputs high together. The square-wave phase after enabling is checked sample by sample, which exposes a divider that is not cleared.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  typedef enum logic [2:0] {
    MD_RST    = 3'd0,
    MD_SIG    = 3'd1,
    MD_CLS    = 3'd2,
    MD_MARK   = 3'd3,
    MD_INRUSH = 3'd4,
    MD_ON     = 3'd5
  } pd_mode_e;

  typedef enum logic [2:0] {
    RG_RST = 3'd0,
    RG_LOW = 3'd1,
    RG_CLS = 3'd2,
    RG_GAP = 3'd3,
    RG_PWR = 3'd4
  } pd_region_e;

  typedef enum logic [1:0] {
    PT_NONE = 2'd0,
    PT_T1   = 2'd1,
    PT_T2   = 2'd2,
    PT_EXT  = 2'd3
  } pse_type_e;
endpackage

// File: rtl/pd_region_dec.sv
module pd_region_dec
  import pd_seq_pkg::*;
#(
  parameter int VW        = 8,
  parameter int RST_TH    = 10,
  parameter int CLS_ENTER = 50,
  parameter int CLS_EXIT  = 46,
  parameter int CLS_TOP   = 84,
  parameter int ON_STD    = 148,
  parameter int OFF_STD   = 120,
  parameter int ON_LV     = 116,
  parameter int OFF_LV    = 86
) (
  input  logic [VW-1:0] code_i,
  input  logic          low_volt_i,
  input  logic          in_cls_i,
  input  logic          powered_i,
  output pd_region_e    region_o
);
  localparam logic [VW-1:0] RstC  = VW'(RST_TH);
  localparam logic [VW-1:0] EnC   = VW'(CLS_ENTER);
  localparam logic [VW-1:0] ExC   = VW'(CLS_EXIT);
  localparam logic [VW-1:0] TopC  = VW'(CLS_TOP);
  localparam logic [VW-1:0] OnSC  = VW'(ON_STD);
  localparam logic [VW-1:0] OffSC = VW'(OFF_STD);
  localparam logic [VW-1:0] OnLC  = VW'(ON_LV);
  localparam logic [VW-1:0] OffLC = VW'(OFF_LV);

  logic [VW-1:0] on_th, off_th, cls_lo;

  always_comb begin
    on_th  = low_volt_i ? OnLC : OnSC;
    off_th = low_volt_i ? OffLC : OffSC;
    // hysteresis: staying in classification needs less than entering it
    cls_lo = in_cls_i ? ExC : EnC;
    if (code_i < RstC)                      region_o = RG_RST;
    else if (powered_i && code_i >= off_th) region_o = RG_PWR;
    else if (code_i < cls_lo)               region_o = RG_LOW;
    else if (code_i <= TopC)                region_o = RG_CLS;
    else if (code_i > on_th)                region_o = RG_PWR;
    else                                    region_o = RG_GAP;
  end
endmodule

// File: rtl/pd_debounce.sv
module pd_debounce
  import pd_seq_pkg::*;
#(
  parameter int DEB_LEN = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  pd_region_e raw_i,
  output pd_region_e stable_o
);
  localparam int CW = $clog2(DEB_LEN + 1);

  pd_region_e    stable_q, cand_q;
  logic [CW-1:0] cnt_q, cnt_nxt;

  always_comb cnt_nxt = (raw_i == cand_q) ? cnt_q + 1'b1 : CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stable_q <= RG_RST;
      cand_q   <= RG_RST;
      cnt_q    <= '0;
    end else if (raw_i == stable_q) begin
      cand_q <= raw_i;
      cnt_q  <= '0;
    end else begin
      cand_q <= raw_i;
      if (cnt_nxt >= CW'(DEB_LEN)) begin
        stable_q <= raw_i;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_nxt;
      end
    end
  end

  assign stable_o = stable_q;
endmodule

// File: rtl/pd_mode_fsm.sv
module pd_mode_fsm
  import pd_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  pd_region_e region_i,
  input  logic       gate_enh_i,
  input  logic       ext_id_i,
  input  logic       hold_i,
  output pd_mode_e   mode_o,
  output pse_type_e  type_o
);
  pd_mode_e  mode_q, mode_d;
  pse_type_e type_q, type_d;
  logic [1:0] ev_q, ev_d;

  always_comb begin
    mode_d = mode_q;
    type_d = type_q;
    ev_d   = ev_q;
    if (hold_i || region_i == RG_RST) begin
      mode_d = MD_RST;
      type_d = PT_NONE;
      ev_d   = '0;
    end else begin
      unique case (mode_q)
        MD_RST, MD_SIG, MD_MARK: begin
          if (region_i == RG_LOW && mode_q != MD_MARK) mode_d = MD_SIG;
          else if (region_i == RG_CLS) begin
            mode_d = MD_CLS;
            ev_d   = (ev_q == 2'd2) ? 2'd2 : ev_q + 2'd1;
          end else if (region_i == RG_PWR) begin
            mode_d = MD_INRUSH;
            type_d = (ev_q >= 2'd2) ? PT_T2 : PT_T1;
          end
        end
        MD_CLS: begin
          if (region_i == RG_LOW) mode_d = MD_MARK;
          else if (region_i == RG_PWR) begin
            mode_d = MD_INRUSH;
            type_d = (ev_q >= 2'd2) ? PT_T2 : PT_T1;
          end
        end
        MD_INRUSH, MD_ON: begin
          if (region_i != RG_PWR) begin
            // port lost: restart the sequence from signature
            mode_d = MD_SIG;
            type_d = PT_NONE;
            ev_d   = '0;
          end else if (mode_q == MD_INRUSH) begin
            if (gate_enh_i) mode_d = MD_ON;
          end else if (ext_id_i) begin
            type_d = PT_EXT;
          end
        end
        default: mode_d = MD_RST;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MD_RST;
      type_q <= PT_NONE;
      ev_q   <= '0;
    end else begin
      mode_q <= mode_d;
      type_q <= type_d;
      ev_q   <= ev_d;
    end
  end

  assign mode_o = mode_q;
  assign type_o = type_q;
endmodule

// File: rtl/pd_ind_gen.sv
module pd_ind_gen #(
  parameter int HALF_CYC = 74405
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic line_o
);
  localparam int CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] Last = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          ph_q;

  // idle keeps the divider cleared so each enable starts with a low half
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (cnt_q == Last) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign line_o = ph_q;
endmodule

// File: rtl/pd_mode_seq.sv
module pd_mode_seq
  import pd_seq_pkg::*;
#(
  parameter int VW           = 8,
  parameter int DEB_LEN      = 4,
  parameter int IND_HALF_CYC = 74405,
  parameter int RST_TH       = 10,
  parameter int CLS_ENTER    = 50,
  parameter int CLS_EXIT     = 46,
  parameter int CLS_TOP      = 84,
  parameter int ON_STD       = 148,
  parameter int OFF_STD      = 120,
  parameter int ON_LV        = 116,
  parameter int OFF_LV       = 86
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [VW-1:0] vport_code_i,
  input  logic          low_volt_i,
  input  logic          gate_enh_i,
  input  logic          ext_id_i,
  input  logic          ext_fitted_i,
  input  logic          aux_i,
  input  logic          otemp_i,
  output logic          sig_load_o,
  output logic          cls_load_o,
  output logic          mark_load_o,
  output logic          gate_on_o,
  output logic          pgood_o,
  output logic          type_o,
  output logic [2:0]    mode_o
);
  pd_mode_e   mode;
  pse_type_e  ptype;
  pd_region_e reg_raw, reg_stable;
  logic       ind_en, sq_line;

  pd_region_dec #(
    .VW(VW), .RST_TH(RST_TH), .CLS_ENTER(CLS_ENTER), .CLS_EXIT(CLS_EXIT),
    .CLS_TOP(CLS_TOP), .ON_STD(ON_STD), .OFF_STD(OFF_STD),
    .ON_LV(ON_LV), .OFF_LV(OFF_LV)
  ) u_dec (
    .code_i     (vport_code_i),
    .low_volt_i (low_volt_i),
    .in_cls_i   (mode == MD_CLS),
    .powered_i  (mode == MD_INRUSH || mode == MD_ON),
    .region_o   (reg_raw)
  );

  pd_debounce #(.DEB_LEN(DEB_LEN)) u_deb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .raw_i    (reg_raw),
    .stable_o (reg_stable)
  );

  pd_mode_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .region_i   (reg_stable),
    .gate_enh_i (gate_enh_i),
    .ext_id_i   (ext_id_i),
    .hold_i     (aux_i | otemp_i),
    .mode_o     (mode),
    .type_o     (ptype)
  );

  pd_ind_gen #(.HALF_CYC(IND_HALF_CYC)) u_ind (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ind_en),
    .line_o (sq_line)
  );

  // precedence: over-temperature, auxiliary, then the mode sequence
  always_comb begin
    sig_load_o  = 1'b0;
    cls_load_o  = 1'b0;
    mark_load_o = 1'b0;
    gate_on_o   = 1'b0;
    pgood_o     = 1'b0;
    type_o      = 1'b1;
    ind_en      = 1'b0;
    if (otemp_i) begin
      pgood_o = 1'b0;
    end else if (aux_i) begin
      pgood_o = 1'b1;
      ind_en  = ext_fitted_i;
      type_o  = ext_fitted_i ? sq_line : 1'b0;
    end else begin
      sig_load_o  = (mode == MD_SIG);
      cls_load_o  = (mode == MD_CLS);
      mark_load_o = (mode == MD_MARK);
      gate_on_o   = (mode == MD_INRUSH) || (mode == MD_ON);
      pgood_o     = (mode == MD_ON);
      if (mode == MD_ON) begin
        ind_en = (ptype == PT_EXT);
        unique case (ptype)
          PT_T2:   type_o = 1'b0;
          PT_EXT:  type_o = sq_line;
          default: type_o = 1'b1;
        endcase
      end
    end
  end

  assign mode_o = mode;
endmodule

// File: rtl/pd_mode_seq_chk.sv
module pd_mode_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       gate_enh_i,
  input logic       ext_fitted_i,
  input logic       aux_i,
  input logic       otemp_i,
  input logic       sig_load_o,
  input logic       cls_load_o,
  input logic       mark_load_o,
  input logic       gate_on_o,
  input logic       pgood_o,
  input logic       type_o,
  input logic [2:0] mode_o
);
  // R3
  loads_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sig_load_o, cls_load_o, mark_load_o, gate_on_o}));

  // R4
  mark_from_cls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd3 && $past(mode_o) != 3'd3) |-> $past(mode_o) == 3'd2);

  // R7
  on_needs_enh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd5 && $past(mode_o) == 3'd4) |-> $past(gate_enh_i));

  // R7
  pgood_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pgood_o && !aux_i) |-> gate_on_o);

  // R10
  aux_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_i && !otemp_i) |-> (!gate_on_o && pgood_o && !cls_load_o && !sig_load_o));

  // R11
  aux_unfit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_i && !otemp_i && !ext_fitted_i) |-> !type_o);

  // R12
  otemp_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    otemp_i |=> (mode_o == 3'd0));

  // R12
  otemp_safe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    otemp_i |-> (!gate_on_o && !pgood_o && !cls_load_o));
endmodule

bind pd_mode_seq pd_mode_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .gate_enh_i   (gate_enh_i),
  .ext_fitted_i (ext_fitted_i),
  .aux_i        (aux_i),
  .otemp_i      (otemp_i),
  .sig_load_o   (sig_load_o),
  .cls_load_o   (cls_load_o),
  .mark_load_o  (mark_load_o),
  .gate_on_o    (gate_on_o),
  .pgood_o      (pgood_o),
  .type_o       (type_o),
  .mode_o       (mode_o)
);

// File: tb/pd_mode_seq_bench.sv
module pd_mode_seq_bench;
  localparam int DEB  = 4;
  localparam int HALF = 6;
  localparam int ST   = DEB * 3 + 6;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] vport = '0;
  logic       low_volt = 1'b0, gate_enh = 1'b0, ext_id = 1'b0;
  logic       ext_fitted = 1'b0, aux = 1'b0, otemp = 1'b0;
  logic       sig_load, cls_load, mark_load, gate_on, pgood, type_line;
  logic [2:0] mode;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int mm = 0, mc = 0, mt = 0;

  always #4 clk = ~clk;

  pd_mode_seq #(.DEB_LEN(DEB), .IND_HALF_CYC(HALF)) u_pd_mode_seq (
    .clk_i(clk), .rst_ni(rst_ni), .vport_code_i(vport), .low_volt_i(low_volt),
    .gate_enh_i(gate_enh), .ext_id_i(ext_id), .ext_fitted_i(ext_fitted),
    .aux_i(aux), .otemp_i(otemp), .sig_load_o(sig_load), .cls_load_o(cls_load),
    .mark_load_o(mark_load), .gate_on_o(gate_on), .pgood_o(pgood),
    .type_o(type_line), .mode_o(mode)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(int code, int n);
    vport = 8'(code);
    repeat (n) @(negedge clk);
  endtask

  function automatic int ref_region(int code, bit lv, int md);
    int on_t  = lv ? 116 : 148;
    int off_t = lv ? 86 : 120;
    int lo    = (md == 2) ? 46 : 50;
    if (code < 10) return 0;
    if ((md == 4 || md == 5) && code >= off_t) return 4;
    if (code < lo) return 1;
    if (code <= 84) return 2;
    if (code > on_t) return 4;
    return 3;
  endfunction

  task automatic mstep(int r, bit enh);
    if (r == 0) begin mm = 0; mc = 0; mt = 0; end
    else if (mm == 4 || mm == 5) begin
      if (r != 4) begin mm = 1; mc = 0; mt = 0; end
      else if (mm == 4 && enh) mm = 5;
    end else if (r == 4) begin
      mm = 4; mt = (mc >= 2) ? 2 : 1;
    end else if (r == 2 && mm != 2) begin
      mm = 2; mc = (mc < 2) ? mc + 1 : 2;
    end else if (r == 1) begin
      mm = (mm == 2) ? 3 : (mm == 3) ? 3 : 1;
    end
  endtask

  task automatic pulse_reset();
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int codes[10] = '{5, 20, 44, 48, 60, 90, 100, 118, 125, 150};
    int runs;
    int last;
    int run_len;
    void'($urandom(32'd4275));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 loads", {sig_load, cls_load, mark_load, gate_on}, 0);
    chk("R1 pgood", pgood, 0);
    chk("R1 type", type_line, 1);

    // R3 signature band
    hold(20, ST);
    chk("R3 mode", mode, 1);
    chk("R3 sig_load", sig_load, 1);

    // R2 short excursion ignored, exact acceptance cycle
    hold(60, DEB - 1);
    hold(20, ST);
    chk("R2 glitch", mode, 1);
    hold(60, DEB);
    chk("R2 not yet", mode, 1);
    @(negedge clk);
    chk("R2 accept", mode, 2);
    chk("R4 cls_load", cls_load, 1);

    // R4 hysteresis
    hold(48, ST);
    chk("R4 hold in cls", mode, 2);
    hold(45, ST);
    chk("R4 to mark", mode, 3);
    chk("R4 mark_load", mark_load, 1);
    hold(48, ST);
    chk("R4 mark stays", mode, 3);
    hold(60, ST);
    chk("R4 second event", mode, 2);

    // R6 / R7 / R8 standard thresholds, two-event source
    hold(140, ST);
    chk("R6 below on", gate_on, 0);
    hold(150, ST);
    chk("R6 inrush", mode, 4);
    chk("R7 pgood inrush", pgood, 0);
    chk("R8 type before pgood", type_line, 1);
    gate_enh = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 on", mode, 5);
    chk("R7 pgood", pgood, 1);
    chk("R8 two-event", type_line, 0);
    hold(125, ST);
    chk("R6 stays on", gate_on, 1);
    hold(119, ST);
    chk("R7 drop mode", mode, 1);
    chk("R7 drop pgood", pgood, 0);
    chk("R6 drop gate", gate_on, 0);

    // R5 reset, then single-event source
    hold(5, ST);
    chk("R5 rest", mode, 0);
    hold(20, ST);
    hold(60, ST);
    hold(150, ST);
    chk("R8 one-event on", mode, 5);
    chk("R8 one-event", type_line, 1);
    hold(5, ST);
    chk("R5 clear", mode, 0);

    // R6 low-voltage thresholds
    hold(120, ST);
    chk("R6 std gap", mode, 0);
    low_volt = 1'b1;
    repeat (ST) @(negedge clk);
    chk("R6 lv on", mode, 5);
    hold(90, ST);
    chk("R6 lv hold", gate_on, 1);

    // R9 extended source square wave run lengths
    ext_id = 1'b1;
    repeat (3) @(negedge clk);
    runs = 0; last = type_line; run_len = 0;
    for (int i = 0; i < 8 * HALF; i++) begin
      @(negedge clk);
      if (type_line != last) begin
        if (runs > 0) chk("R9 half period", run_len + 1, HALF);
        runs++; run_len = 0; last = type_line;
      end else run_len++;
    end
    chk("R9 toggles", (runs >= 5) ? 1 : 0, 1);
    ext_id = 1'b0;
    hold(85, ST);
    chk("R6 lv drop", mode, 1);

    // R10 / R11 auxiliary override
    hold(150, ST);
    aux = 1'b1;
    @(negedge clk);
    chk("R10 gate", gate_on, 0);
    chk("R10 pgood", pgood, 1);
    chk("R10 mode", mode, 0);
    chk("R11 unfitted", type_line, 0);
    aux = 1'b0;
    ext_fitted = 1'b1;
    @(negedge clk);
    aux = 1'b1;
    for (int j = 1; j <= 4 * HALF; j++) begin
      @(negedge clk);
      chk("R11 fitted phase", type_line, ((j / HALF) % 2 == 1) ? 1 : 0);
    end

    // R12 over-temperature precedence
    otemp = 1'b1;
    @(negedge clk);
    chk("R12 pgood", pgood, 0);
    chk("R12 type", type_line, 1);
    aux = 1'b0;
    otemp = 1'b0;
    ext_fitted = 1'b0;
    repeat (ST) @(negedge clk);
    chk("R12 back on", mode, 5);
    otemp = 1'b1;
    @(negedge clk);
    chk("R12 gate", gate_on, 0);
    chk("R12 mode", mode, 0);
    hold(60, ST);
    chk("R12 no class", cls_load, 0);
    otemp = 1'b0;
    low_volt = 1'b0;

    // R2..R8 random walk against the bench model
    hold(5, ST);
    gate_enh = 1'b0;
    pulse_reset();
    mm = 0; mc = 0; mt = 0;
    for (int s = 0; s < 200; s++) begin
      int c = codes[$urandom % 10];
      bit lv = 1'($urandom % 2);
      bit en = 1'($urandom % 2);
      low_volt = lv;
      gate_enh = en;
      hold(c, ST);
      for (int k = 0; k < 4; k++) mstep(ref_region(c, lv, mm), en);
      chk("R4 random mode", mode, mm);
      chk("R6 random gate", gate_on, (mm >= 4) ? 1 : 0);
      chk("R7 random pgood", pgood, (mm == 5) ? 1 : 0);
      chk("R8 random type", type_line, (mm == 5 && mt == 2) ? 0 : 1);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule